// File: doc/BRIEF.md
# SDRAM Row/Column Address Multiplexer

This block sits between a memory sequencer and the address pins of an SDRAM. It takes a flat word address from the requester and splits it into column, row and bank fields. The column occupies the lowest address bits, the row sits directly above it, and the bank sits above the row. As a result, a linear sweep of addresses covers every column of a row, then every row of a bank, and then moves on to the next bank. Where the fields fall depends on two configuration inputs: the page size (256, 512 or 1024 words) and the data-bus width (32 or 64 bits).

The sequencer issues one command per cycle. The block then drives the shared address bus and the bank-select lines on the following clock edge:
- For an activate, it drives the row.
- For a read or write, it drives the column.
- For a burst step, it drives the next column, wrapping inside the page.

Address bit 10 has its own output. It carries row bit 10 during activate, is low during column phases, and is forced high for precharge-all and refresh.

The block also remembers the bank and row that were last activated. From these it reports, combinationally, whether the current request address is a page hit, a bank miss or a row miss. The sequencer uses these flags to decide between a direct column command and a precharge/activate cycle.

Top module: `sdram_addr_mux`

## Requirements
- R1: After reset, `sd_addr`, `sd_a10` and `sd_ba` are zero and no row is open, so `page_hit` is 0 and both `bank_miss` and `row_miss` are 1.
- R2: The column width is 8, 9 or 10 bits for `cfg_page` = 0, 1 and 2 (a value of 3 behaves as 2). When `cfg_wide`=1 (64-bit bus), address bit 0 selects the 32-bit half and the column starts at bit 1. When `cfg_wide`=0, the column starts at bit 0.
- R3: The row field lies directly above the column. It is 13 bits wide for a 64-bit bus and 14 bits wide for a 32-bit bus.
- R4: The bank field (2 bits) lies directly above the row. It appears on `sd_ba` one cycle after an activate or read/write command.
- R5: On activate (`cmd`=1), the next cycle shows the row on `sd_addr`. Row bit 10 goes to `sd_a10`, and `sd_addr[10]` is 0.
- R6: On read/write (`cmd`=2), the next cycle shows the column on `sd_addr`. All bits above the column are 0, and `sd_a10` is 0.
- R7: On burst step (`cmd`=3), the next cycle shows the last driven column plus one. The last column of the page wraps to column 0, and `sd_ba` is unchanged.
- R8: On precharge-all (`cmd`=4) or refresh (`cmd`=5), the next cycle shows `sd_a10`=1 and `sd_addr`=0.
- R9: On idle (`cmd`=0, 6 or 7), the bus outputs hold their values.
- R10: Activate records the open bank and row. `page_hit` is 1 exactly when the request address has that bank and that row.
- R11: `bank_miss` is 1 when no row is open or the request bank differs from the open bank. `row_miss` is 1 when no row is open or the request row differs from the open row.
- R12: Precharge-all clears the open row, so every address then reports two misses. Refresh leaves the open-row state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_page | input | 2 | Page size select: 0=256, 1=512, 2/3=1024 words |
| cfg_wide | input | 1 | 1 = 64-bit data bus, 0 = 32-bit |
| cmd | input | 3 | 0 idle, 1 activate, 2 read/write, 3 burst step, 4 precharge-all, 5 refresh |
| req_addr | input | 26 | Flat word address of the request |
| sd_addr | output | 14 | Multiplexed SDRAM address (bit 10 always 0) |
| sd_a10 | output | 1 | Dedicated SDRAM A10 line |
| sd_ba | output | 2 | SDRAM bank select |
| page_hit | output | 1 | Request matches the open bank and row |
| bank_miss | output | 1 | No open row, or request bank differs |
| row_miss | output | 1 | No open row, or request row differs |

## Verification
The assertions assume two things about the inputs: `cfg_page` and `cfg_wide` change only while the sequencer has no open row, and `req_addr` is held while a command is presented. The post-activate hit property also depends on the address and configuration staying stable into the next cycle, and it only fires when they do.

The stimulus changes configuration only after a precharge-all. It drives the command and address at the falling edge and holds them across the rising edge. For every combination of page size and bus width, it sweeps spread addresses, and it places burst steps at the last column of a page.

// File: rtl/sdram_addr_mux.sv
module sdram_addr_mux #(
  parameter int ADDR_W  = 26,
  parameter int COL_MAX = 10,
  parameter int ROW64_W = 13,
  parameter int ROW32_W = 14,
  parameter int BANK_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_page,
  input  logic                 cfg_wide,
  input  logic [2:0]           cmd,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic [13:0]          sd_addr,
  output logic                 sd_a10,
  output logic [BANK_W-1:0]    sd_ba,
  output logic                 page_hit,
  output logic                 bank_miss,
  output logic                 row_miss
);
  localparam int ROW_MAX = (ROW64_W > ROW32_W) ? ROW64_W : ROW32_W;
  localparam logic [2:0] C_ACT = 3'd1, C_RW = 3'd2, C_SEQ = 3'd3, C_PREA = 3'd4, C_REF = 3'd5;

  logic [3:0]          col_w;
  logic [4:0]          row_w;
  logic [ADDR_W-1:0]   sh_col, sh_row, sh_bank;
  logic [COL_MAX-1:0]  col_mask, a_col, col_q, col_nx;
  logic [ROW_MAX-1:0]  row_mask, a_row, row_bus, open_row;
  logic [BANK_W-1:0]   a_bank, open_bank;
  logic                open_v;

  assign col_w    = (cfg_page == 2'd0) ? 4'd8 : (cfg_page == 2'd1) ? 4'd9 : 4'd10;
  assign row_w    = cfg_wide ? 5'(ROW64_W) : 5'(ROW32_W);
  assign col_mask = ~({COL_MAX{1'b1}} << col_w);
  assign row_mask = ~({ROW_MAX{1'b1}} << row_w);

  assign sh_col  = req_addr >> cfg_wide;
  assign sh_row  = sh_col >> col_w;
  assign sh_bank = sh_row >> row_w;

  assign a_col   = sh_col[COL_MAX-1:0] & col_mask;
  assign a_row   = sh_row[ROW_MAX-1:0] & row_mask;
  assign a_bank  = sh_bank[BANK_W-1:0];
  assign row_bus = a_row & ~(ROW_MAX'(1) << 10);
  assign col_nx  = (col_q + COL_MAX'(1)) & col_mask;

  assign bank_miss = !open_v || (a_bank != open_bank);
  assign row_miss  = !open_v || (a_row != open_row);
  assign page_hit  = !bank_miss && !row_miss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_addr   <= '0;
      sd_a10    <= 1'b0;
      sd_ba     <= '0;
      col_q     <= '0;
      open_v    <= 1'b0;
      open_bank <= '0;
      open_row  <= '0;
    end else begin
      case (cmd)
        C_ACT: begin
          sd_addr   <= 14'(row_bus);
          sd_a10    <= a_row[10];
          sd_ba     <= a_bank;
          open_v    <= 1'b1;
          open_bank <= a_bank;
          open_row  <= a_row;
        end
        C_RW: begin
          sd_addr <= 14'(a_col);
          sd_a10  <= 1'b0;
          sd_ba   <= a_bank;
          col_q   <= a_col;
        end
        C_SEQ: begin
          sd_addr <= 14'(col_nx);
          sd_a10  <= 1'b0;
          col_q   <= col_nx;
        end
        C_PREA: begin
          sd_addr <= '0;
          sd_a10  <= 1'b1;
          open_v  <= 1'b0;
        end
        C_REF: begin
          sd_addr <= '0;
          sd_a10  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_A10_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PREA || cmd == C_REF) |=> (sd_a10 && sd_addr == '0)); // R8
  AST_COL_A10_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RW || cmd == C_SEQ) |=> (!sd_a10 && sd_addr[13:10] == '0)); // R6
  AST_ROW_BIT10_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |=> !sd_addr[10]); // R5
  AST_SEQ_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_SEQ) |=> $stable(sd_ba)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd0) |=> ($stable(sd_addr) && $stable(sd_a10) && $stable(sd_ba))); // R9
  AST_HIT_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |=> (($stable(req_addr) && $stable(cfg_page) && $stable(cfg_wide)) -> page_hit)); // R10
  AST_PREA_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PREA) |=> (bank_miss && row_miss && !page_hit)); // R12
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    page_hit |-> (!bank_miss && !row_miss)); // R11
endmodule

// File: tb/sdram_addr_mux_tb.sv
module sdram_addr_mux_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_page = 2'd0;
  logic        cfg_wide = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [25:0] req_addr = '0;
  logic [13:0] sd_addr;
  logic        sd_a10, page_hit, bank_miss, row_miss;
  logic [1:0]  sd_ba;

  int n_chk = 0, n_bad = 0;
  int ov = 0, ob = 0, orow = 0;
  int e_addr = 0, e_a10 = 0, e_ba = 0, e_col = 0;

  always #5 clk = ~clk;

  sdram_addr_mux dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_page(cfg_page), .cfg_wide(cfg_wide),
    .cmd(cmd), .req_addr(req_addr), .sd_addr(sd_addr), .sd_a10(sd_a10),
    .sd_ba(sd_ba), .page_hit(page_hit), .bank_miss(bank_miss), .row_miss(row_miss)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pw();   return 256 << ((cfg_page > 2) ? 2 : cfg_page); endfunction
  function automatic int half(); return cfg_wide ? 2 : 1; endfunction
  function automatic int nrow(); return cfg_wide ? 8192 : 16384; endfunction
  function automatic int f_col(int a);  return (a / half()) % pw(); endfunction
  function automatic int f_row(int a);  return (a / (half() * pw())) % nrow(); endfunction
  function automatic int f_bank(int a); return (a / (half() * pw() * nrow())) % 4; endfunction

  task automatic issue(input int c, input int a);
    int mb, mr, r;
    @(negedge clk);
    cmd = 3'(c);
    req_addr = 26'(a);
    #1;
    mb = (ov == 0 || f_bank(a) != ob) ? 1 : 0;
    mr = (ov == 0 || f_row(a) != orow) ? 1 : 0;
    chk("R11 bank_miss", int'(bank_miss), mb);
    chk("R11 row_miss", int'(row_miss), mr);
    chk("R10 page_hit", int'(page_hit), (mb == 0 && mr == 0) ? 1 : 0);
    case (c)
      1: begin
        r = f_row(a);
        e_a10 = (r >> 10) & 1;
        e_addr = r - e_a10 * 1024;
        e_ba = f_bank(a);
        ov = 1; ob = e_ba; orow = r;
      end
      2: begin e_col = f_col(a); e_addr = e_col; e_a10 = 0; e_ba = f_bank(a); end
      3: begin e_col = (e_col + 1) % pw(); e_addr = e_col; e_a10 = 0; end
      4: begin e_addr = 0; e_a10 = 1; ov = 0; end
      5: begin e_addr = 0; e_a10 = 1; end
      default: ;
    endcase
    @(posedge clk);
    #1;
    case (c)
      1: chk("R5 R3 row on bus", int'(sd_addr), e_addr);
      2: chk("R6 R2 column on bus", int'(sd_addr), e_addr);
      3: chk("R7 burst step column", int'(sd_addr), e_addr);
      4, 5: chk("R8 all-bank address", int'(sd_addr), e_addr);
      default: chk("R9 idle hold", int'(sd_addr), e_addr);
    endcase
    chk("R5 R8 a10 line", int'(sd_a10), e_a10);
    chk("R4 bank select", int'(sd_ba), e_ba);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sd_addr", int'(sd_addr), 0);
    chk("R1 sd_a10", int'(sd_a10), 0);
    chk("R1 sd_ba", int'(sd_ba), 0);
    chk("R1 page_hit", int'(page_hit), 0);
    chk("R1 bank_miss", int'(bank_miss), 1);
    chk("R1 row_miss", int'(row_miss), 1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int w = 0; w < 2; w++) begin
      for (int p = 0; p < 4; p++) begin
        issue(4, 0);
        @(negedge clk);
        cfg_wide = w[0];
        cfg_page = 2'(p);
        for (int i = 0; i < 40; i++) begin
          int a;
          a = (i * 2654435 + p * 99991 + w * 31337 + 7) % (1 << 26);
          issue(2, a);
          issue(1, a);
          issue(2, a);
          issue(3, a);
          issue(0, a ^ (1 << 20));
          issue(2, a ^ 1);
          if (i % 5 == 0) issue(5, a);
          issue(2, a ^ (1 << 22));
          if (i % 7 == 0) issue(4, a);
        end
        for (int k = 0; k < 4; k++) begin
          int a;
          a = ((k * nrow() + (nrow() - 1 - k)) * pw() + (pw() - 1)) * half() + w;
          issue(1, a);
          issue(2, a);
          issue(3, a);
          issue(3, a);
          issue(6, a);
        end
        issue(4, 0);
        issue(2, 12345);
        issue(7, 0);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule